// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher

This block watches the current time of day (seconds, minutes, hours and day of month, each a 7-bit BCD value) and raises a sticky alarm flag when the time agrees with a set of programmable alarm registers. Each alarm register is eight bits wide. The low seven bits hold the BCD value to compare. The top bit is an active-low select: a 0 in that bit makes the field take part in the comparison. Because of this, software chooses how often the alarm repeats by choosing which select bits it clears. With no fields selected the alarm fires every second. Selecting seconds only gives one alarm per minute. Adding minutes gives one per hour, adding hours gives one per day, and selecting all four gives one exact date and time.

The comparison is made only on the one-second update strobe that comes from the timekeeping logic. This means a matching second sets the flag exactly once. The flag is reported in a flags byte. Reading that byte clears the flag, but a match that arrives in the same cycle as the read takes priority. An interrupt output follows the flag whenever the interrupt enable is high.

Top module: `rtc_alarm_match`

## Requirements
- R1: While `rst_n` is low at a clock edge, the alarm flag is cleared, `irq` reads 0, and every alarm register is set to 8'hFF, which means no field is selected.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored into the alarm register chosen by `wr_sel` (0 = seconds, 1 = minutes, 2 = hours, 3 = date). The new value is used for comparisons from the next edge onward.
- R3: A field whose register bit 7 is 0 matches only when the register's bits 6:0 equal that field of `time_bcd`. The field layout is seconds in bits 6:0, minutes in bits 13:7, hours in bits 20:14 and date in bits 27:21. A field whose bit 7 is 1 is ignored.
- R4: The alarm condition is the AND of all selected field comparisons, whatever the combination of select bits. With no field selected, every strobe counts as a match.
- R5: The alarm condition is only evaluated at edges where `sec_tick` is high. Without the strobe, the flag is never set.
- R6: Once set, the alarm flag stays at 1 until a flags read.
- R7: `flags_rdata` carries the alarm flag in bit 6 and 0 in every other bit. An edge with `flags_rd` high and no match clears the flag, and the clear is visible after that edge.
- R8: When a match and a flags read occur at the same edge, the flag remains 1.
- R9: `irq` is 1 exactly when the alarm flag is 1 and `int_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Alarm register write strobe |
| wr_sel | input | 2 | Alarm register index (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Write data: bit 7 = select (active low), bits 6:0 = BCD value |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| time_bcd | input | 28 | Current time: date, hours, minutes, seconds, 7 bits each, seconds lowest |
| flags_rd | input | 1 | Flags register read strobe |
| int_en | input | 1 | Interrupt output enable |
| flags_rdata | output | 8 | Flags byte, alarm flag in bit 6 |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The timing of each result is fixed:
- A write, a strobe or a read acts at the edge that samples it. The flag and the `flags_rdata` bit change just after that edge.
- A register write changes only comparisons made at later edges.
- `irq` follows `int_en` and the flag with no added register.

The bench drives inputs one time unit after a rising edge. Its reference model updates on that same edge from the sampled inputs. The outputs are compared at the falling edge, so every check samples a value that has already settled for the current cycle.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants and types for the RTC alarm matcher.
package rtc_alarm_pkg;
    localparam int NUM_FIELDS = 4;              // seconds, minutes, hours, date
    localparam int FIELD_W    = 7;              // BCD width of one time field
    localparam int REG_W      = FIELD_W + 1;    // value plus active-low select
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam int FLAGS_W    = 8;
    localparam int AF_BIT     = 6;              // alarm flag position in flags byte

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } field_e;
endpackage

// File: rtl/rtc_alarm_regs.sv
// Alarm register file: one REG_W-bit register per time field.
// Assumes wr_sel is always below NFIELDS. Resets every register to all
// ones, so no field is selected.
module rtc_alarm_regs #(
    parameter int NFIELDS = 4,
    parameter int RW      = 8,
    localparam int SW     = $clog2(NFIELDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [SW-1:0]              wr_sel_i,
    input  logic [RW-1:0]              wr_data_i,
    output logic [NFIELDS-1:0][RW-1:0] regs_o
);
    logic [NFIELDS-1:0][RW-1:0] regs_q;

    for (genvar f = 0; f < NFIELDS; f++) begin : g_reg
        // Load the addressed register when a write is presented.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[f] <= '1;
            else if (wr_en_i && (wr_sel_i == SW'(f)))
                regs_q[f] <= wr_data_i;
        end
    end

    assign regs_o = regs_q;

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> regs_q[$past(wr_sel_i)] == $past(wr_data_i));
endmodule

// File: rtl/rtc_field_cmp.sv
// Compares one alarm field with the matching time field. The active-low
// select in the register MSB turns the comparison off (forced hit).
module rtc_field_cmp #(
    parameter int FW = 7
) (
    input  logic [FW:0]   alarm_i,
    input  logic [FW-1:0] time_i,
    output logic          hit_o
);
    // A field hits when it is deselected or its BCD value is equal.
    always_comb begin
        hit_o = alarm_i[FW] || (alarm_i[FW-1:0] == time_i);
    end
endmodule

// File: rtl/rtc_alarm_flag.sv
// Sticky alarm flag. Set wins over a read clear in the same cycle.
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    output logic af_o
);
    logic af_q;

    // Hold the flag until a read with no new event clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            af_q <= 1'b0;
        else if (set_i)
            af_q <= 1'b1;
        else if (rd_i)
            af_q <= 1'b0;
    end

    assign af_o = af_q;

    // R5
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!af_q && !set_i) |=> !af_q);
    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (af_q && !rd_i) |=> af_q);
    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !set_i) |=> !af_q);
    // R8
    set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> af_q);
endmodule

// File: rtl/rtc_alarm_match.sv
// Top of the RTC alarm matcher. Field f of time_bcd sits at bits
// f*FIELD_W +: FIELD_W. The comparison is gated by the one-second strobe.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int FW = FIELD_W,
    localparam int RW = FW + 1,
    localparam int SW = $clog2(NF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  logic [RW-1:0]     wr_data,
    input  logic              sec_tick,
    input  logic [NF*FW-1:0]  time_bcd,
    input  logic              flags_rd,
    input  logic              int_en,
    output logic [FLAGS_W-1:0] flags_rdata,
    output logic              alarm_flag,
    output logic              irq
);
    logic [NF-1:0][RW-1:0] alarm_regs;
    logic [NF-1:0]         field_hit;
    logic                  alarm_set;
    logic                  af;

    rtc_alarm_regs #(.NFIELDS(NF), .RW(RW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_sel_i (wr_sel),
        .wr_data_i(wr_data),
        .regs_o   (alarm_regs)
    );

    for (genvar f = 0; f < NF; f++) begin : g_cmp
        rtc_field_cmp #(.FW(FW)) u_cmp (
            .alarm_i(alarm_regs[f]),
            .time_i (time_bcd[f*FW +: FW]),
            .hit_o  (field_hit[f])
        );
    end

    // An event needs the strobe and every field to agree.
    always_comb begin
        alarm_set = sec_tick && (&field_hit);
    end

    rtc_alarm_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(alarm_set),
        .rd_i (flags_rd),
        .af_o (af)
    );

    // Place the flag into the flags byte and drive the interrupt.
    always_comb begin
        flags_rdata         = '0;
        flags_rdata[AF_BIT] = af;
        alarm_flag          = af;
        irq                 = af && int_en;
    end

    // R4
    all_ignored_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (&alarm_regs[0][RW-1]) && (&alarm_regs[1][RW-1]) &&
         (&alarm_regs[2][RW-1]) && (&alarm_regs[3][RW-1])) |=> alarm_flag);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);
endmodule

// File: tb/rtc_alarm_match_tb_top.sv
module rtc_alarm_match_tb_top;
    import rtc_alarm_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic sec_tick = 1'b0;
    logic flags_rd = 1'b0;
    logic int_en = 1'b0;
    logic [6:0] tm [4];
    logic [27:0] time_bcd;
    logic [7:0] flags_rdata;
    logic alarm_flag, irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string phase = "R1";

    logic [7:0] m_reg [4];
    logic m_flag;

    always #4 clk = ~clk;

    assign time_bcd = {tm[3], tm[2], tm[1], tm[0]};

    rtc_alarm_match dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_tick(sec_tick), .time_bcd(time_bcd),
        .flags_rd(flags_rd), .int_en(int_en), .flags_rdata(flags_rdata),
        .alarm_flag(alarm_flag), .irq(irq)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < 4; f++) m_reg[f] <= 8'hFF;
            m_flag <= 1'b0;
        end else begin
            automatic bit hit = sec_tick;
            for (int f = 0; f < 4; f++)
                if (!m_reg[f][7] && (m_reg[f][6:0] != tm[f])) hit = 1'b0;
            if (hit) m_flag <= 1'b1;
            else if (flags_rd) m_flag <= 1'b0;
            if (wr_en) m_reg[wr_sel] <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(alarm_flag == m_flag, phase, alarm_flag, m_flag);
            chk(flags_rdata == {1'b0, m_flag, 6'b0}, {phase, "/R7"}, flags_rdata, {1'b0, m_flag, 6'b0});
            chk(irq == (m_flag && int_en), {phase, "/R9"}, irq, m_flag && int_en);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 1'b0; sec_tick = 1'b0; flags_rd = 1'b0;
    endtask

    task automatic wr(input int sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
        step();
    endtask

    task automatic tick(input logic [6:0] s, input logic [6:0] mi,
                        input logic [6:0] h, input logic [6:0] d, input bit rd);
        tm[0] = s; tm[1] = mi; tm[2] = h; tm[3] = d;
        sec_tick = 1'b1; flags_rd = rd;
        step();
    endtask

    task automatic rd();
        flags_rd = 1'b1;
        step();
    endtask

    initial begin
        for (int f = 0; f < 4; f++) tm[f] = '0;
        repeat (3) step();
        // R1 reset state
        chk(alarm_flag == 1'b0, "R1", alarm_flag, 0);
        chk(irq == 1'b0, "R1", irq, 0);
        rst_n = 1'b1;
        step();
        // R4: all fields ignored after reset, any strobe matches
        phase = "R4";
        tick(7'h12, 7'h34, 7'h05, 7'h09, 1'b0);
        chk(alarm_flag == 1'b1, "R4", alarm_flag, 1);
        // R7: read clears
        phase = "R7";
        rd();
        chk(alarm_flag == 1'b0, "R7", alarm_flag, 0);
        // R5: no strobe, no set
        phase = "R5";
        repeat (4) step();
        chk(alarm_flag == 1'b0, "R5", alarm_flag, 0);
        // R3: seconds selected
        phase = "R3";
        wr(FLD_SEC, 8'h30);
        tick(7'h29, 7'h00, 7'h00, 7'h01, 1'b0);
        chk(alarm_flag == 1'b0, "R3", alarm_flag, 0);
        tick(7'h30, 7'h41, 7'h11, 7'h02, 1'b0);
        chk(alarm_flag == 1'b1, "R3", alarm_flag, 1);
        rd();
        // R2 / R4: minutes and hours added
        phase = "R2";
        wr(FLD_MIN, 8'h15);
        wr(FLD_HOUR, 8'h07);
        tick(7'h30, 7'h14, 7'h07, 7'h01, 1'b0);
        chk(alarm_flag == 1'b0, "R2", alarm_flag, 0);
        tick(7'h30, 7'h15, 7'h08, 7'h01, 1'b0);
        chk(alarm_flag == 1'b0, "R4", alarm_flag, 0);
        tick(7'h30, 7'h15, 7'h07, 7'h01, 1'b0);
        chk(alarm_flag == 1'b1, "R4", alarm_flag, 1);
        rd();
        // Exact date and R6 stickiness
        phase = "R6";
        wr(FLD_DATE, 8'h21);
        tick(7'h30, 7'h15, 7'h07, 7'h20, 1'b0);
        chk(alarm_flag == 1'b0, "R4", alarm_flag, 0);
        tick(7'h30, 7'h15, 7'h07, 7'h21, 1'b0);
        repeat (5) step();
        chk(alarm_flag == 1'b1, "R6", alarm_flag, 1);
        // R9 interrupt enable
        phase = "R9";
        int_en = 1'b1;
        step();
        chk(irq == 1'b1, "R9", irq, 1);
        int_en = 1'b0;
        #1;
        chk(irq == 1'b0, "R9", irq, 0);
        rd();
        // Unusual combination: date only
        phase = "R4";
        wr(FLD_SEC, 8'h80);
        wr(FLD_MIN, 8'hFF);
        wr(FLD_HOUR, 8'h87);
        wr(FLD_DATE, 8'h12);
        tick(7'h59, 7'h02, 7'h23, 7'h12, 1'b0);
        chk(alarm_flag == 1'b1, "R4", alarm_flag, 1);
        // R8: match and read together
        phase = "R8";
        tick(7'h01, 7'h03, 7'h00, 7'h12, 1'b1);
        chk(alarm_flag == 1'b1, "R8", alarm_flag, 1);
        tick(7'h01, 7'h03, 7'h00, 7'h13, 1'b1);
        chk(alarm_flag == 1'b0, "R7", alarm_flag, 0);
        // R2: write in same cycle as strobe uses the old value
        phase = "R2";
        wr_en = 1'b1; wr_sel = 2'(FLD_DATE); wr_data = 8'h14;
        tick(7'h00, 7'h00, 7'h00, 7'h14, 1'b0);
        chk(alarm_flag == 1'b0, "R2", alarm_flag, 0);
        tick(7'h00, 7'h00, 7'h00, 7'h14, 1'b0);
        chk(alarm_flag == 1'b1, "R2", alarm_flag, 1);
        // R1: reset again clears everything
        phase = "R1";
        rst_n = 1'b0;
        step();
        chk(alarm_flag == 1'b0, "R1", alarm_flag, 0);
        rst_n = 1'b1;
        tick(7'h44, 7'h44, 7'h04, 7'h04, 1'b0);
        chk(alarm_flag == 1'b1, "R1", alarm_flag, 1);
        step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule